// File: doc/BRIEF.md
# Collision-Avoidance MII Transmit Data Controller

This block sits on the 4-bit MII transmit path between a MAC and a PHY on a shared multidrop medium where stations take turns instead of colliding. While the avoidance scheme is running, it lets a MAC frame onto the line only when the station holds a transmit opportunity. A MAC that starts early gets a collision indication, and the block then keeps the frame pending until an opportunity comes. While the line is not being used for data, it sends control symbols encoded from a command input.

When the scheme is not operational, the status input reads FAIL and the block is transparent: the MAC's enable, data and error lines reach the PHY unchanged. The transmit opportunity, the status and the command are produced elsewhere and arrive here as plain inputs. Every PHY-side output is registered, so it lags the MAC side by exactly one clock.

Top module: `ca_tx_data`

## Requirements
- R1: While rst_ni is low, phy_txen_o, phy_txd_o, phy_txer_o and col_o are all 0, and the controller is held in its pass-through state.
- R2: Status is encoded as 1 = OK and 0 = FAIL. When status_i is FAIL at a clock edge, the controller is in pass-through after that edge, whatever state it was in, and col_o is 0.
- R3: At an edge where the next state is pass-through, the outputs take the values of mac_txen_i, mac_txd_i and mac_txer_i sampled at that edge. From pass-through, an edge with status OK moves the controller to idle.
- R4: cmd_i is registered on each rising edge (0 = none, 1 = beacon, 2 = commit, 3 = treated as none). In every state other than pass-through and transmit, phy_txen_o is 0 and {phy_txer_o, phy_txd_o} is taken from the registered command: none gives 0/0000, beacon gives 1/1000, commit gives 1/0011. A change on cmd_i therefore reaches the outputs at the second edge after it is applied.
- R5: From idle, tx_opp_i high moves the controller to wait-for-MAC. From wait-for-MAC, it moves to transmit only when tx_opp_i and mac_txen_i are both high. It returns to idle when tx_opp_i is low, and otherwise stays in wait-for-MAC.
- R6: In transmit, phy_txen_o is 1 and the MAC's data and error are forwarded with a one-clock lag, starting with the nibble sampled at the edge that enters transmit. The controller returns to idle at the edge where mac_txen_i is low.
- R7: In idle, mac_txen_i high with tx_opp_i low enters the collide state and raises col_o. The controller stays there while mac_txen_i is high, then goes to pending.
- R8: Pending stays put while tx_opp_i and mac_txen_i are both low. tx_opp_i high moves it to hold. mac_txen_i high alone moves it to a deferral state that raises col_o until mac_txen_i falls, and then the controller returns to pending.
- R9: In hold, mac_txen_i high enters transmit. After HOLD_MAX consecutive edges in hold with mac_txen_i low, the controller enters abort. mac_txen_i high at the HOLD_MAX-th edge still wins. Abort stays while tx_opp_i is high, ignores mac_txen_i, and returns to idle when tx_opp_i is low.
- R10: col_o is 1 only in collide and deferral, and phy_txen_o is 0 whenever col_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | MII transmit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| status_i | input | 1 | Scheme status, 1 = OK, 0 = FAIL |
| tx_opp_i | input | 1 | Station currently holds a transmit opportunity |
| cmd_i | input | 2 | Control-symbol command |
| mac_txen_i | input | 1 | MAC transmit enable |
| mac_txd_i | input | DATA_W | MAC transmit data nibble |
| mac_txer_i | input | 1 | MAC transmit error |
| phy_txen_o | output | 1 | Transmit enable toward the PHY |
| phy_txd_o | output | DATA_W | Transmit data toward the PHY |
| phy_txer_o | output | 1 | Transmit error toward the PHY |
| col_o | output | 1 | Collision indication toward the MAC |

## Verification
The bench builds the block with HOLD_MAX = 4 and the default 4-bit data width, so the hold timeout is reached after a handful of cycles. With that value, both sides of the abort boundary are covered: a MAC that starts on the last permitted edge is transmitted, and a MAC that stays silent through it is aborted. The bench can only see the internal states through the outputs. It tells them apart by stimuli whose reactions differ between states, such as a MAC enable that is forwarded from hold but ignored in abort, and by MAC data values that differ from the encoded control symbols.

// File: rtl/ca_tx_pkg.sv
package ca_tx_pkg;

  localparam int unsigned CMD_W = 2;

  typedef enum logic [3:0] {
    S_NORMAL     = 4'd0,
    S_IDLE       = 4'd1,
    S_WAIT_MAC   = 4'd2,
    S_TRANSMIT   = 4'd3,
    S_HOLD       = 4'd4,
    S_PENDING    = 4'd5,
    S_DELAY_PEND = 4'd6,
    S_COLLIDE    = 4'd7,
    S_ABORT      = 4'd8
  } ca_state_e;

  typedef enum logic [CMD_W-1:0] {
    CMD_NONE   = 2'd0,
    CMD_BEACON = 2'd1,
    CMD_COMMIT = 2'd2,
    CMD_RSVD   = 2'd3
  } ca_cmd_e;

  typedef enum logic {
    STAT_FAIL = 1'b0,
    STAT_OK   = 1'b1
  } ca_status_e;

endpackage

// File: rtl/ca_tx_cmd_sync.sv
module ca_tx_cmd_sync #(
  parameter int unsigned CMD_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CMD_W-1:0] cmd_i,
  output logic [CMD_W-1:0] cmd_q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmd_q_o <= '0;
    else         cmd_q_o <= cmd_i;
  end

endmodule

// File: rtl/ca_tx_ctrl.sv
module ca_tx_ctrl
  import ca_tx_pkg::*;
#(
  parameter int unsigned HOLD_MAX = 16
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      status_i,
  input  logic      tx_opp_i,
  input  logic      mac_txen_i,
  output ca_state_e state_d_o,
  output ca_state_e state_q_o
);

  localparam int unsigned CNT_W = (HOLD_MAX > 1) ? $clog2(HOLD_MAX) : 1;

  ca_state_e state_q, state_d;
  logic      hold_expired;

  generate
    if (HOLD_MAX > 0) begin : g_hold_cnt
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                cnt_q <= '0;
        else if (state_q != S_HOLD)                 cnt_q <= '0;
        else if (cnt_q != CNT_W'(HOLD_MAX - 1))     cnt_q <= cnt_q + 1'b1;
      end
      assign hold_expired = (cnt_q == CNT_W'(HOLD_MAX - 1));
    end else begin : g_no_hold_cnt
      assign hold_expired = 1'b0;
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_NORMAL:     state_d = S_IDLE;
      S_IDLE: begin
        if (tx_opp_i)        state_d = S_WAIT_MAC;
        else if (mac_txen_i) state_d = S_COLLIDE;
      end
      S_WAIT_MAC: begin
        if (tx_opp_i && mac_txen_i) state_d = S_TRANSMIT;
        else if (!tx_opp_i)         state_d = S_IDLE;
      end
      S_TRANSMIT:   if (!mac_txen_i) state_d = S_IDLE;
      S_COLLIDE:    if (!mac_txen_i) state_d = S_PENDING;
      S_PENDING: begin
        if (tx_opp_i)        state_d = S_HOLD;
        else if (mac_txen_i) state_d = S_DELAY_PEND;
      end
      S_DELAY_PEND: if (!mac_txen_i) state_d = S_PENDING;
      S_HOLD: begin
        if (mac_txen_i)        state_d = S_TRANSMIT;
        else if (hold_expired) state_d = S_ABORT;
      end
      S_ABORT:      if (!tx_opp_i) state_d = S_IDLE;
      default:      state_d = S_NORMAL;
    endcase
    // status override has top priority from any state
    if (status_i != STAT_OK) state_d = S_NORMAL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_NORMAL;
    else         state_q <= state_d;
  end

  assign state_d_o = state_d;
  assign state_q_o = state_q;

endmodule

// File: rtl/ca_tx_outreg.sv
module ca_tx_outreg
  import ca_tx_pkg::*;
#(
  parameter int unsigned       DATA_W  = 4,
  parameter logic [DATA_W-1:0] BCN_TXD = DATA_W'(4'b1000),
  parameter logic [DATA_W-1:0] CMT_TXD = DATA_W'(4'b0011)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ca_state_e         state_d_i,
  input  logic [CMD_W-1:0]  cmd_q_i,
  input  logic              mac_txen_i,
  input  logic [DATA_W-1:0] mac_txd_i,
  input  logic              mac_txer_i,
  output logic              phy_txen_o,
  output logic [DATA_W-1:0] phy_txd_o,
  output logic              phy_txer_o
);

  logic              enc_txer;
  logic [DATA_W-1:0] enc_txd;

  always_comb begin
    unique case (ca_cmd_e'(cmd_q_i))
      CMD_BEACON: begin enc_txer = 1'b1; enc_txd = BCN_TXD; end
      CMD_COMMIT: begin enc_txer = 1'b1; enc_txd = CMT_TXD; end
      default:    begin enc_txer = 1'b0; enc_txd = '0;      end
    endcase
  end

  // outputs follow the state being entered, so no MAC nibble is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phy_txen_o <= 1'b0;
      phy_txd_o  <= '0;
      phy_txer_o <= 1'b0;
    end else if (state_d_i == S_NORMAL) begin
      phy_txen_o <= mac_txen_i;
      phy_txd_o  <= mac_txd_i;
      phy_txer_o <= mac_txer_i;
    end else if (state_d_i == S_TRANSMIT) begin
      phy_txen_o <= 1'b1;
      phy_txd_o  <= mac_txd_i;
      phy_txer_o <= mac_txer_i;
    end else begin
      phy_txen_o <= 1'b0;
      phy_txd_o  <= enc_txd;
      phy_txer_o <= enc_txer;
    end
  end

endmodule

// File: rtl/ca_tx_data.sv
module ca_tx_data
  import ca_tx_pkg::*;
#(
  parameter int unsigned       DATA_W   = 4,
  parameter int unsigned       HOLD_MAX = 16,
  parameter logic [DATA_W-1:0] BCN_TXD  = DATA_W'(4'b1000),
  parameter logic [DATA_W-1:0] CMT_TXD  = DATA_W'(4'b0011)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              status_i,
  input  logic              tx_opp_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic              mac_txen_i,
  input  logic [DATA_W-1:0] mac_txd_i,
  input  logic              mac_txer_i,
  output logic              phy_txen_o,
  output logic [DATA_W-1:0] phy_txd_o,
  output logic              phy_txer_o,
  output logic              col_o
);

  ca_state_e        state_d, state_q;
  logic [CMD_W-1:0] cmd_q;

  ca_tx_cmd_sync #(.CMD_W(CMD_W)) i_cmd_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cmd_i   (cmd_i),
    .cmd_q_o (cmd_q)
  );

  ca_tx_ctrl #(.HOLD_MAX(HOLD_MAX)) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .status_i   (status_i),
    .tx_opp_i   (tx_opp_i),
    .mac_txen_i (mac_txen_i),
    .state_d_o  (state_d),
    .state_q_o  (state_q)
  );

  ca_tx_outreg #(
    .DATA_W  (DATA_W),
    .BCN_TXD (BCN_TXD),
    .CMT_TXD (CMT_TXD)
  ) i_outreg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .state_d_i  (state_d),
    .cmd_q_i    (cmd_q),
    .mac_txen_i (mac_txen_i),
    .mac_txd_i  (mac_txd_i),
    .mac_txer_i (mac_txer_i),
    .phy_txen_o (phy_txen_o),
    .phy_txd_o  (phy_txd_o),
    .phy_txer_o (phy_txer_o)
  );

  assign col_o = (state_q == S_COLLIDE) || (state_q == S_DELAY_PEND);

endmodule

// File: rtl/ca_tx_data_chk.sv
module ca_tx_data_chk
  import ca_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              status_i,
  input logic              tx_opp_i,
  input logic              mac_txen_i,
  input logic [DATA_W-1:0] mac_txd_i,
  input logic              mac_txer_i,
  input logic              phy_txen_o,
  input logic [DATA_W-1:0] phy_txd_o,
  input logic              phy_txer_o,
  input logic              col_o,
  input ca_state_e         state_q
);

  p_fail_enters_normal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_i |=> state_q == S_NORMAL);

  p_normal_copies_mac_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_i |=> (phy_txen_o == $past(mac_txen_i) && phy_txd_o == $past(mac_txd_i)
                   && phy_txer_o == $past(mac_txer_i)));

  p_wait_needs_both_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WAIT_MAC && status_i && !(tx_opp_i && mac_txen_i)) |=> state_q != S_TRANSMIT);

  p_wait_stays_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WAIT_MAC && status_i && tx_opp_i && !mac_txen_i) |=> state_q == S_WAIT_MAC);

  p_tx_ends_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_TRANSMIT && status_i && !mac_txen_i) |=> state_q == S_IDLE);

  p_pending_stays_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_PENDING && status_i && !tx_opp_i && !mac_txen_i) |=> state_q == S_PENDING);

  p_abort_waits_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_ABORT && status_i && tx_opp_i) |=> state_q == S_ABORT);

  p_col_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_o |-> !phy_txen_o);

endmodule

bind ca_tx_data ca_tx_data_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .status_i   (status_i),
  .tx_opp_i   (tx_opp_i),
  .mac_txen_i (mac_txen_i),
  .mac_txd_i  (mac_txd_i),
  .mac_txer_i (mac_txer_i),
  .phy_txen_o (phy_txen_o),
  .phy_txd_o  (phy_txd_o),
  .phy_txer_o (phy_txer_o),
  .col_o      (col_o),
  .state_q    (state_q)
);

// File: tb/test_ca_tx_data.sv
`timescale 1ns/1ps
module test_ca_tx_data;

  localparam int unsigned HM = 4;

  typedef enum {K_P, K_T, K_E} kind_e;
  typedef struct {
    logic       txen;
    logic [3:0] txd;
    logic       txer;
    logic       col;
    string      tag;
  } item_t;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       status_i = 1'b0;
  logic       tx_opp_i = 1'b0;
  logic [1:0] cmd_i = 2'd0;
  logic       mac_txen_i = 1'b0;
  logic [3:0] mac_txd_i = 4'h0;
  logic       mac_txer_i = 1'b0;
  logic       phy_txen_o, phy_txer_o, col_o;
  logic [3:0] phy_txd_o;

  int    n_chk = 0;
  int    n_err = 0;
  bit    done = 1'b0;
  item_t q[$];
  logic [1:0] prev_cmd = 2'd0;

  always #2.5 clk_i = ~clk_i;

  ca_tx_data #(.DATA_W(4), .HOLD_MAX(HM)) i_ca_tx_data (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .status_i   (status_i),
    .tx_opp_i   (tx_opp_i),
    .cmd_i      (cmd_i),
    .mac_txen_i (mac_txen_i),
    .mac_txd_i  (mac_txd_i),
    .mac_txer_i (mac_txer_i),
    .phy_txen_o (phy_txen_o),
    .phy_txd_o  (phy_txd_o),
    .phy_txer_o (phy_txer_o),
    .col_o      (col_o)
  );

  // R4 encoding table
  function automatic logic [4:0] enc(input logic [1:0] c);
    case (c)
      2'd1:    return 5'b1_1000;
      2'd2:    return 5'b1_0011;
      default: return 5'b0_0000;
    endcase
  endfunction

  task automatic check(input logic [6:0] act, input logic [6:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got txen=%b txd=%h txer=%b col=%b, expected txen=%b txd=%h txer=%b col=%b",
               tag, act[6], act[5:2], act[1], act[0], exp[6], exp[5:2], exp[1], exp[0]);
    end
  endtask

  task automatic step(input logic st, input logic opp, input logic en, input logic [3:0] d,
                      input logic er, input logic [1:0] c, input kind_e k, input logic col,
                      input string tag);
    item_t it;
    logic [4:0] e;
    @(negedge clk_i);
    status_i = st; tx_opp_i = opp; mac_txen_i = en; mac_txd_i = d; mac_txer_i = er; cmd_i = c;
    e = enc(prev_cmd);
    case (k)
      K_P:     begin it.txen = en;   it.txd = d;      it.txer = er;   end
      K_T:     begin it.txen = 1'b1; it.txd = d;      it.txer = er;   end
      default: begin it.txen = 1'b0; it.txd = e[3:0]; it.txer = e[4]; end
    endcase
    it.col = col;
    it.tag = tag;
    q.push_back(it);
    prev_cmd = c;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check({phy_txen_o, phy_txd_o, phy_txer_o, col_o}, {it.txen, it.txd, it.txer, it.col}, it.tag);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    mac_txen_i = 1'b1; mac_txd_i = 4'hF; mac_txer_i = 1'b1; cmd_i = 2'd1;
    repeat (3) @(posedge clk_i);
    #1;
    check({phy_txen_o, phy_txd_o, phy_txer_o, col_o}, 7'b0, "R1 reset outputs");
    @(negedge clk_i);
    cmd_i = 2'd0; mac_txen_i = 1'b0; mac_txd_i = 4'h0; mac_txer_i = 1'b0;
    rst_ni = 1'b1;

    // R3 pass-through, then leave to idle
    step(0, 0, 1, 4'h5, 1, 0, K_P, 0, "R3 pass a");
    step(0, 1, 0, 4'hA, 0, 0, K_P, 0, "R3 pass b");
    step(1, 0, 0, 4'hC, 1, 0, K_E, 0, "R3 leave to idle");
    // R4 command encodings, two-edge latency
    step(1, 0, 0, 4'h6, 0, 1, K_E, 0, "R4 none");
    step(1, 0, 0, 4'h6, 0, 1, K_E, 0, "R4 beacon");
    step(1, 0, 0, 4'h6, 0, 2, K_E, 0, "R4 beacon hold");
    step(1, 0, 0, 4'h6, 0, 2, K_E, 0, "R4 commit");
    step(1, 0, 0, 4'h6, 0, 3, K_E, 0, "R4 commit hold");
    step(1, 0, 0, 4'h6, 0, 3, K_E, 0, "R4 reserved as none");
    step(1, 0, 0, 4'h6, 0, 0, K_E, 0, "R4 none again");
    // R5 / R6 opportunity path
    step(1, 1, 0, 4'h1, 0, 0, K_E, 0, "R5 to wait");
    step(1, 1, 0, 4'h1, 0, 0, K_E, 0, "R5 wait stays");
    step(1, 0, 0, 4'h1, 0, 0, K_E, 0, "R5 wait to idle");
    step(1, 1, 0, 4'h1, 0, 0, K_E, 0, "R5 to wait again");
    step(1, 1, 1, 4'h3, 0, 0, K_T, 0, "R6 first nibble");
    step(1, 1, 1, 4'h9, 1, 0, K_T, 0, "R6 second nibble");
    step(1, 0, 0, 4'h9, 1, 0, K_E, 0, "R6 end to idle");
    step(1, 1, 1, 4'h7, 0, 0, K_E, 0, "R5 idle needs wait first");
    step(1, 1, 1, 4'h7, 0, 0, K_T, 0, "R5 wait to transmit");
    step(1, 0, 0, 4'h7, 0, 0, K_E, 0, "R6 end");
    // R7 collide
    step(1, 0, 1, 4'h2, 0, 0, K_E, 1, "R7 collide");
    step(1, 0, 1, 4'h2, 0, 0, K_E, 1, "R7 collide stays");
    step(1, 0, 0, 4'h2, 0, 0, K_E, 0, "R7 to pending");
    // R8 pending / deferral / hold
    step(1, 0, 0, 4'h2, 0, 0, K_E, 0, "R8 pending stays");
    step(1, 0, 1, 4'h2, 0, 0, K_E, 1, "R8 deferral");
    step(1, 0, 1, 4'h2, 0, 0, K_E, 1, "R10 deferral stays");
    step(1, 0, 0, 4'h2, 0, 0, K_E, 0, "R8 back to pending");
    step(1, 1, 0, 4'h2, 0, 0, K_E, 0, "R8 to hold");
    step(1, 0, 1, 4'h6, 1, 0, K_T, 0, "R9 hold to transmit");
    step(1, 0, 0, 4'h6, 1, 0, K_E, 0, "R6 end after hold");
    // R9 last permitted edge
    step(1, 0, 1, 4'h4, 0, 0, K_E, 1, "R9 collide a");
    step(1, 0, 0, 4'h4, 0, 0, K_E, 0, "R9 pending a");
    step(1, 1, 0, 4'h4, 0, 0, K_E, 0, "R9 hold a");
    for (int i = 0; i < HM - 1; i++) step(1, 0, 0, 4'h4, 0, 0, K_E, 0, "R9 hold wait a");
    step(1, 0, 1, 4'hB, 0, 0, K_T, 0, "R9 boundary transmit");
    step(1, 0, 0, 4'hB, 0, 0, K_E, 0, "R9 end a");
    // R9 abort
    step(1, 0, 1, 4'h4, 0, 0, K_E, 1, "R9 collide b");
    step(1, 0, 0, 4'h4, 0, 0, K_E, 0, "R9 pending b");
    step(1, 1, 0, 4'h4, 0, 0, K_E, 0, "R9 hold b");
    for (int i = 0; i < HM - 1; i++) step(1, 0, 0, 4'h4, 0, 0, K_E, 0, "R9 hold wait b");
    step(1, 0, 0, 4'h4, 0, 0, K_E, 0, "R9 to abort");
    step(1, 1, 1, 4'hD, 1, 0, K_E, 0, "R9 abort ignores mac");
    step(1, 1, 0, 4'hD, 1, 0, K_E, 0, "R9 abort stays");
    step(1, 0, 0, 4'hD, 1, 0, K_E, 0, "R9 abort to idle");
    step(1, 0, 1, 4'hD, 0, 0, K_E, 1, "R9 idle confirmed");
    // R2 status FAIL overrides
    step(0, 0, 1, 4'hE, 0, 0, K_P, 0, "R2 from collide");
    step(1, 0, 0, 4'hE, 1, 0, K_E, 0, "R3 back to idle");
    step(1, 0, 1, 4'h8, 0, 0, K_E, 1, "R7 collide c");
    step(1, 0, 0, 4'h8, 0, 0, K_E, 0, "R7 pending c");
    step(1, 1, 0, 4'h8, 0, 0, K_E, 0, "R8 hold c");
    step(0, 0, 0, 4'hF, 1, 0, K_P, 0, "R2 from hold");
    step(0, 1, 1, 4'h3, 0, 0, K_P, 0, "R2 stays normal");

    repeat (3) @(posedge clk_i);
    #2;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule